// File: doc/BRIEF.md
# Self-Test Sequence Interval Watchdog

This block watches how often each self-test algorithm begins its sequence. There is one timer per algorithm, and each runs on its own. A timer restarts whenever its algorithm reports the start of step 0. If the gap to the next step-0 start is longer than a programmable safe period, the timer raises a timeout flag for that algorithm. It does not matter whether the conversions were started by software or by a hardware trigger. Normal conversions that run between two self-test sequences simply count as elapsed time.

Enabling a timer also starts a count. This catches a sequence that never begins at all: after the enable, the first step 0 has to arrive within the same safe period. The block only receives start strobes and does not generate them. Each strobe carries an algorithm number and a step number.

The timers count in clock cycles. The package provides a default safe period of 1,200,000 cycles, which is 10 ms with a 120 MHz clock. Integration logic may use it as the reset value of the safe-period register that drives `safe_period_i`.

Top module: `stw_seq_watchdog`

## Requirements
- R1: After synchronous reset all bits of `timeout_o` are 0.
- R2: The block has NUM_ALG timers (default 3), one per algorithm. A strobe, enable change or timeout of one algorithm never changes another algorithm's flag.
- R3: A step-0 start for algorithm a is a clock edge with `start_valid_i`=1, `start_alg_i`=a and `start_step_i`=0. It restarts timer a. The start is on time if it is sampled no more than P edges after the previous restart, where P = `safe_period_i`. An on-time start never raises a flag.
- R4: If P edges pass after a restart of an enabled timer with no step-0 start for that algorithm, the flag is set by the P-th edge. It is visible right after that edge, and the counter then holds.
- R5: The first edge at which `enable_i[a]` is sampled high counts as a restart. The first step 0 must therefore arrive within P edges of the enable, or R4 applies.
- R6: A set flag stays set while the enable stays high. A later step-0 start restarts counting but does not clear the flag.
- R7: An edge with `enable_i[a]`=0 clears flag a and its counter. No timeout is raised while the timer is disabled.
- R8: Strobes with a non-zero step number, with another algorithm's number, or with an algorithm number of NUM_ALG or above have no effect on timer a.
- R9: With P=0, an enabled timer sets its flag on the first edge after a restart that carries no step-0 start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | NUM_ALG | Per-algorithm timer enable |
| safe_period_i | input | CNT_W | Safe period P in clock cycles |
| start_valid_i | input | 1 | Step-start strobe |
| start_alg_i | input | ALG_W | Algorithm number of the strobe |
| start_step_i | input | STEP_W | Step number of the strobe (0 = first step) |
| timeout_o | output | NUM_ALG | Sticky per-algorithm timeout flags |

## Verification
Four properties are checked on every cycle for each algorithm:
- an edge with the enable low leaves the flag clear;
- a set flag stays set while the enable is high;
- a flag can only rise after an enabled edge that saw no step-0 start for that algorithm;
- an edge that carries a step-0 start never makes the flag rise.

The exact deadline cannot be seen from these properties alone. This covers the edge on which a late start is flagged, the boundary where a start at exactly P edges is still on time, the deadline that follows an enable, and the zero-period case. Only the bench scenarios, with their counted cycle offsets, show these. The same holds for the fact that strobes carrying a wrong step or algorithm leave the deadline unchanged.

// File: rtl/stw_pkg.sv
package stw_pkg;

    // Default safe period: 10 ms at 120 MHz
    localparam int unsigned DEFAULT_SAFE_PERIOD = 1_200_000;
    localparam int unsigned DEFAULT_CNT_W       = 24;

    // Per-timer control state
    typedef struct packed {
        logic armed;    // enable seen on the previous edge
        logic expired;  // counter frozen after a miss
        logic flag;     // sticky timeout
    } stw_state_t;

    // True when one more elapsed cycle reaches the limit
    function automatic logic limit_reached(input logic [31:0] cnt,
                                           input logic [31:0] lim);
        return ({1'b0, cnt} + 33'd1) >= {1'b0, lim};
    endfunction

endpackage

// File: rtl/stw_strobe_decode.sv
module stw_strobe_decode #(
    parameter int unsigned NUM_ALG = 3,
    parameter int unsigned ALG_W   = 2,
    parameter int unsigned STEP_W  = 3
) (
    input  logic              valid_i,
    input  logic [ALG_W-1:0]  alg_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [NUM_ALG-1:0] hit_o
);

    logic first_step;
    assign first_step = valid_i && (step_i == '0);

    for (genvar g = 0; g < NUM_ALG; g++) begin : g_hit
        assign hit_o[g] = first_step && (alg_i == ALG_W'(g));
    end

endmodule

// File: rtl/stw_timer.sv
module stw_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             timeout_o
);
    import stw_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    stw_state_t       st_q;
    logic             due;

    assign due = limit_reached(32'(cnt_q), 32'(period_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            st_q  <= '0;
        end else begin
            st_q.armed <= en_i;
            if (!en_i) begin
                cnt_q        <= '0;
                st_q.expired <= 1'b0;
                st_q.flag    <= 1'b0;
            end else if (hit_i || !st_q.armed) begin
                cnt_q        <= '0;
                st_q.expired <= 1'b0;
            end else if (!st_q.expired) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (due) begin
                    st_q.expired <= 1'b1;
                    st_q.flag    <= 1'b1;
                end
            end
        end
    end

    assign timeout_o = st_q.flag;

endmodule

// File: rtl/stw_seq_watchdog.sv
module stw_seq_watchdog #(
    parameter int unsigned NUM_ALG = 3,
    parameter int unsigned STEP_W  = 3,
    parameter int unsigned CNT_W   = stw_pkg::DEFAULT_CNT_W,
    localparam int unsigned ALG_W  = (NUM_ALG > 1) ? $clog2(NUM_ALG) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_ALG-1:0] enable_i,
    input  logic [CNT_W-1:0]   safe_period_i,
    input  logic               start_valid_i,
    input  logic [ALG_W-1:0]   start_alg_i,
    input  logic [STEP_W-1:0]  start_step_i,
    output logic [NUM_ALG-1:0] timeout_o
);

    logic [NUM_ALG-1:0] hit;

    stw_strobe_decode #(
        .NUM_ALG(NUM_ALG),
        .ALG_W  (ALG_W),
        .STEP_W (STEP_W)
    ) u_decode (
        .valid_i(start_valid_i),
        .alg_i  (start_alg_i),
        .step_i (start_step_i),
        .hit_o  (hit)
    );

    for (genvar a = 0; a < NUM_ALG; a++) begin : g_timer
        stw_timer #(
            .CNT_W(CNT_W)
        ) u_timer (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .en_i     (enable_i[a]),
            .hit_i    (hit[a]),
            .period_i (safe_period_i),
            .timeout_o(timeout_o[a])
        );
    end

endmodule

// File: rtl/stw_seq_watchdog_chk.sv
module stw_seq_watchdog_chk #(
    parameter int unsigned NUM_ALG = 3,
    parameter int unsigned ALG_W   = 2,
    parameter int unsigned STEP_W  = 3,
    parameter int unsigned CNT_W   = 24
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_ALG-1:0] enable_i,
    input logic [CNT_W-1:0]   safe_period_i,
    input logic               start_valid_i,
    input logic [ALG_W-1:0]   start_alg_i,
    input logic [STEP_W-1:0]  start_step_i,
    input logic [NUM_ALG-1:0] timeout_o
);

    logic [NUM_ALG-1:0] seen0;
    for (genvar a = 0; a < NUM_ALG; a++) begin : g_seen
        assign seen0[a] = start_valid_i && (start_step_i == '0)
                          && (32'(start_alg_i) == a);
    end

    for (genvar a = 0; a < NUM_ALG; a++) begin : g_chk
        // R7
        disabled_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !enable_i[a] |=> !timeout_o[a]);
        // R6
        flag_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (enable_i[a] && timeout_o[a]) |=> timeout_o[a]);
        // R4
        rise_needs_miss_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(timeout_o[a]) |-> $past(enable_i[a] && !seen0[a]));
        // R3
        start_no_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (enable_i[a] && seen0[a]) |=> !$rose(timeout_o[a]));
    end

    // CNT_W width is only used to match the bound ports
    logic unused_ok;
    assign unused_ok = ^safe_period_i;

endmodule

bind stw_seq_watchdog stw_seq_watchdog_chk #(
    .NUM_ALG(NUM_ALG),
    .ALG_W  (ALG_W),
    .STEP_W (STEP_W),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/stw_seq_watchdog_bench.sv
module stw_seq_watchdog_bench;
    import stw_pkg::*;

    localparam int unsigned NA = 3;
    localparam int unsigned SW = 3;
    localparam int unsigned CW = 24;
    localparam int unsigned AW = 2;
    localparam int unsigned P  = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [NA-1:0] en;
    logic [CW-1:0] period;
    logic          sv;
    logic [AW-1:0] salg;
    logic [SW-1:0] sstep;
    logic [NA-1:0] tmo;

    always #10 clk = ~clk;   // 50 MHz

    stw_seq_watchdog #(.NUM_ALG(NA), .STEP_W(SW), .CNT_W(CW)) u_stw_seq_watchdog (
        .clk_i(clk), .rst_i(rst), .enable_i(en), .safe_period_i(period),
        .start_valid_i(sv), .start_alg_i(salg), .start_step_i(sstep),
        .timeout_o(tmo)
    );

    typedef struct {
        logic [NA-1:0] flags;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // Scoreboard monitor: compares after each falling edge
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (tmo !== e.flags) begin
                failures++;
                $display("FAIL %s: timeout=%b expected %b", e.tag, tmo, e.flags);
            end
        end
    end

    task automatic expect_flags(input logic [NA-1:0] m, input string tag);
        exp_t e;
        e.flags = m;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-edge strobe; returns just after the edge that sampled it
    task automatic pulse(input logic [AW-1:0] a, input logic [SW-1:0] s);
        sv = 1'b1; salg = a; sstep = s;
        @(negedge clk);
        sv = 1'b0; salg = '0; sstep = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = '0; period = CW'(DEFAULT_SAFE_PERIOD);
        sv = 1'b0; salg = '0; sstep = '0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        expect_flags(3'b000, "R1 reset state");
        period = CW'(P);

        // R5 / R3: first start exactly P edges after enable is on time
        en = 3'b001;
        cyc(1);
        cyc(P - 1);
        expect_flags(3'b000, "R5 before first start");
        pulse(2'd0, 3'd0);
        expect_flags(3'b000, "R3 start at P edges on time");

        // R4: missed start flagged on the P-th edge
        cyc(P - 1);
        expect_flags(3'b000, "R4 one edge before deadline");
        cyc(1);
        expect_flags(3'b001, "R4 flag at deadline (R2 others clear)");

        // R6: sticky through later starts
        pulse(2'd0, 3'd0);
        expect_flags(3'b001, "R6 flag kept after start");
        cyc(15);
        expect_flags(3'b001, "R6 flag kept over time");

        // R7: disable clears and suppresses
        en = 3'b000;
        cyc(1);
        expect_flags(3'b000, "R7 disable clears flag");
        cyc(20);
        expect_flags(3'b000, "R7 no timeout while disabled");

        // R8: wrong step / wrong algorithm / out-of-range algorithm ignored
        en = 3'b001;
        cyc(1);
        cyc(5);
        pulse(2'd0, 3'd3);
        pulse(2'd1, 3'd0);
        pulse(2'd3, 3'd0);
        cyc(1);
        expect_flags(3'b000, "R8 before deadline");
        cyc(1);
        expect_flags(3'b001, "R8 ignored strobes kept deadline");

        // R2: alg2 served every 5 edges, alg1 starved
        en = 3'b110;
        cyc(1);
        for (int i = 0; i < 4; i++) begin
            cyc(4);
            pulse(2'd2, 3'd0);
            expect_flags((i == 0) ? 3'b000 : 3'b010, "R2 independent timers");
        end

        // R5: no start after enable -> timeout
        en = 3'b000;
        cyc(1);
        en = 3'b010;
        cyc(1);
        cyc(P - 1);
        expect_flags(3'b000, "R5 enable deadline not yet");
        cyc(1);
        expect_flags(3'b010, "R5 enable deadline missed");

        // R9: zero period
        en = 3'b000;
        cyc(1);
        expect_flags(3'b000, "R7 clear before zero-period test");
        period = '0;
        en = 3'b001;
        cyc(1);
        expect_flags(3'b000, "R9 restart edge no flag");
        cyc(1);
        expect_flags(3'b001, "R9 zero period flags next edge");

        // R3: repeated on-time starts never flag
        en = 3'b000;
        period = CW'(P);
        cyc(1);
        en = 3'b100;
        cyc(1);
        for (int i = 0; i < 3; i++) begin
            cyc(P - 1);
            pulse(2'd2, 3'd0);
            expect_flags(3'b000, "R3 repeated on-time starts");
        end

        cyc(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule